// File: doc/BRIEF.md
# Monte Carlo Hit-or-Miss Integrator

This block estimates the volume under the surface f(x, y) = x·y over the unit square by hit-or-miss sampling. A start pulse latches a sample count N and a seed. The block then draws N points (x, y, t) from three pseudo-random shift-register generators, one per coordinate. A point scores a hit when t lies on or below the surface at (x, y). When the last point has been scored, a sequential divider turns the hit count into a fixed-point fraction. The block raises a one-cycle done pulse and holds the estimate until the next start.

All three coordinates are 16-bit unsigned fractions in [0, 1), so the bounding box has unit volume and the estimate is the hit ratio itself. The result has 16 fractional bits and one integer bit, so an estimate of exactly 1.0 (every point a hit) can still be represented. The control sequence is deterministic for a given seed and N, so an exact software model can reproduce every result.

Top module: `mc_integrator`

## Requirements
- R1: While reset is held and in the first cycle after it is released, busy, done and result are all 0.
- R2: Each coordinate generator is a 16-bit register that shifts left by one place per sample. The new LSB is the XOR of bits 15, 14, 12 and 3. Sample i (counting from 1) uses each generator's state after i steps from its seed.
- R3: The x generator is seeded with the seed input, the y generator with the seed XOR 0x5A5A, and the t generator with the seed XOR 0xC3C3. Any derived seed equal to zero is replaced by 0xACE1.
- R4: A sample is a hit when t·2^16 ≤ x·y, where x, y and t are read as unsigned integers. This is the same as t ≤ floor(x·y / 2^16).
- R5: When N is nonzero, the result equals floor(hits·2^16 / N), as a 17-bit unsigned value that never exceeds 2^16.
- R6: Done is high for exactly one cycle and busy is low in that cycle. A start accepted while idle clears the result to 0. The result then holds its value until done, and after done until the next accepted start.
- R7: Busy rises in the cycle after an accepted start. A start pulse while busy has no effect on the running job or its result.
- R8: A start with N = 0 raises done in the next cycle with a result of 0, and busy stays low.
- R9: N and the seed are captured at start. Changing n_samples or seed while busy does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a job when idle |
| n_samples | input | NW (20) | Number of samples N |
| seed | input | W (16) | Seed for the three generators |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| result | output | W+1 (17) | Estimate with 16 fractional bits |

## Verification
Almost every internal fault ends up in the single result value. A wrong generator step, a wrong seed, a wrong compare or a wrong accumulator makes the hit count differ from the bench's exact model. That difference shows up only once, when done pulses, roughly 3N plus 36 cycles after start. The protocol faults show up much sooner. A done that lasts more than one cycle, a result that drifts while held, a start that restarts a running job, and N = 0 that does not complete in one cycle are all visible within a cycle or two of the event that caused them. A long run is also checked against the expected value of 0.25, which catches a generator that is badly correlated even though it matches its own model.

// File: rtl/mc_pkg.sv
package mc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SAMPLE = 3'd1,
        ST_EVAL   = 3'd2,
        ST_ACCUM  = 3'd3,
        ST_FINISH = 3'd4
    } mc_state_e;
endpackage

// File: rtl/mc_lfsr.sv
module mc_lfsr #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    TAPS = 16'hD008
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         step,
    output logic [W-1:0] q
);
    logic [W-1:0] state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load)
            state_d = seed;
        else if (step)
            state_d = {state_q[W-2:0], ^(state_q & TAPS)};
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign q = state_q;
endmodule

// File: rtl/mc_surface.sv
module mc_surface #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] t,
    output logic         under
);
    logic [2*W-1:0] prod;
    assign prod  = x * y;
    // t <= floor(prod / 2^W) is the same as t * 2^W <= prod
    assign under = ({t, {W{1'b0}}} <= prod);
endmodule

// File: rtl/mc_divider.sv
module mc_divider #(
    parameter int NW = 20,
    parameter int DW = 36,
    parameter int QW = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [DW-1:0] dividend,
    input  logic [NW-1:0] divisor,
    output logic          fin,
    output logic [QW-1:0] quo
);
    localparam int CW = $clog2(DW);

    typedef struct packed {
        logic [NW:0]   rem;
        logic [DW-1:0] quo;
        logic [NW-1:0] dv;
        logic [CW-1:0] cnt;
        logic          run;
        logic          fin;
    } div_t;

    div_t r_d, r_q;
    logic [NW:0] sh;
    logic        ge;

    always_comb begin
        r_d     = r_q;
        r_d.fin = 1'b0;
        sh      = {r_q.rem[NW-1:0], r_q.quo[DW-1]};
        ge      = (sh >= {1'b0, r_q.dv});
        if (go) begin
            r_d.rem = '0;
            r_d.quo = dividend;
            r_d.dv  = divisor;
            r_d.cnt = '0;
            r_d.run = 1'b1;
        end else if (r_q.run) begin
            r_d.rem = ge ? (sh - {1'b0, r_q.dv}) : sh;
            r_d.quo = {r_q.quo[DW-2:0], ge};
            r_d.cnt = r_q.cnt + CW'(1);
            if (r_q.cnt == CW'(DW - 1)) begin
                r_d.run = 1'b0;
                r_d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign fin = r_q.fin;
    assign quo = r_q.quo[QW-1:0];
endmodule

// File: rtl/mc_integrator.sv
module mc_integrator
    import mc_pkg::*;
#(
    parameter int           W        = 16,
    parameter int           NW       = 20,
    parameter logic [W-1:0] TAPS     = 16'hD008,
    parameter logic [W-1:0] SALT_Y   = 16'h5A5A,
    parameter logic [W-1:0] SALT_T   = 16'hC3C3,
    parameter logic [W-1:0] FALLBACK = 16'hACE1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [NW-1:0] n_samples,
    input  logic [W-1:0]  seed,
    output logic          busy,
    output logic          done,
    output logic [W:0]    result
);
    localparam int RW = W + 1;
    localparam int DW = NW + W;
    localparam int NC = 3;

    typedef struct packed {
        mc_state_e     st;
        logic [NW-1:0] n;
        logic [NW-1:0] cnt;
        logic [NW-1:0] hits;
        logic          hit;
        logic [RW-1:0] res;
        logic          done;
        logic          div_go;
    } ctl_t;

    ctl_t r_d, r_q;

    logic [W-1:0]  coord [NC];
    logic          gen_load, gen_step, surf_hit, div_fin;
    logic [RW-1:0] div_quo;

    assign gen_load = (r_q.st == ST_IDLE) && start;
    assign gen_step = (r_q.st == ST_SAMPLE);

    for (genvar g = 0; g < NC; g++) begin : g_gen
        localparam logic [W-1:0] SALT = (g == 0) ? '0 : (g == 1) ? SALT_Y : SALT_T;
        logic [W-1:0] raw, sd;
        assign raw = seed ^ SALT;
        assign sd  = (raw == '0) ? FALLBACK : raw;
        mc_lfsr #(.W(W), .TAPS(TAPS)) u_lfsr (
            .clk  (clk),
            .rst  (rst),
            .load (gen_load),
            .seed (sd),
            .step (gen_step),
            .q    (coord[g])
        );
    end

    mc_surface #(.W(W)) u_surface (
        .x     (coord[0]),
        .y     (coord[1]),
        .t     (coord[2]),
        .under (surf_hit)
    );

    mc_divider #(.NW(NW), .DW(DW), .QW(RW)) u_div (
        .clk      (clk),
        .rst      (rst),
        .go       (r_q.div_go),
        .dividend ({r_q.hits, {W{1'b0}}}),
        .divisor  (r_q.n),
        .fin      (div_fin),
        .quo      (div_quo)
    );

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        r_d.div_go = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.res = '0;
                    if (n_samples == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.n    = n_samples;
                        r_d.cnt  = '0;
                        r_d.hits = '0;
                        r_d.st   = ST_SAMPLE;
                    end
                end
            end
            ST_SAMPLE: r_d.st = ST_EVAL;
            ST_EVAL: begin
                r_d.hit = surf_hit;
                r_d.st  = ST_ACCUM;
            end
            ST_ACCUM: begin
                r_d.hits = r_q.hits + NW'(r_q.hit);
                r_d.cnt  = r_q.cnt + NW'(1);
                if ((r_q.cnt + NW'(1)) == r_q.n) begin
                    r_d.st     = ST_FINISH;
                    r_d.div_go = 1'b1;
                end else begin
                    r_d.st = ST_SAMPLE;
                end
            end
            ST_FINISH: begin
                if (div_fin) begin
                    r_d.res  = div_quo;
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy   = (r_q.st != ST_IDLE);
    assign done   = r_q.done;
    assign result = r_q.res;
endmodule

// File: rtl/mc_integrator_chk.sv
module mc_integrator_chk #(
    parameter int W  = 16,
    parameter int NW = 20
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [NW-1:0] n_samples,
    input logic          busy,
    input logic          done,
    input logic [W:0]    result
);
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_idle_at_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r6_result_hold: assert property (@(posedge clk) disable iff (rst)
        !(start && !busy) |=> ($stable(result) || done));

    a_r5_result_bound: assert property (@(posedge clk) disable iff (rst)
        result <= {1'b1, {W{1'b0}}});

    a_r8_zero_n: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && n_samples == '0) |=> (done && result == '0 && !busy));

    a_r7_busy_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));
endmodule

bind mc_integrator mc_integrator_chk #(.W(W), .NW(NW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .n_samples (n_samples),
    .busy      (busy),
    .done      (done),
    .result    (result)
);

// File: tb/mc_integrator_bench.sv
module mc_integrator_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [19:0] n_samples = '0;
    logic [15:0] seed = '0;
    logic        busy, done;
    logic [16:0] result;

    int checks = 0;
    int fails  = 0;
    int issued = 0;
    int served = 0;
    int last_exp = 0;
    int exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    mc_integrator u_mc_integrator (
        .clk(clk), .rst(rst), .start(start), .n_samples(n_samples),
        .seed(seed), .busy(busy), .done(done), .result(result)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R2: shift left, new LSB = b15^b14^b12^b3
    function automatic logic [15:0] step16(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
    endfunction

    // R3: derived seeds, zero replaced
    function automatic logic [15:0] mkseed(input logic [15:0] s, input logic [15:0] salt);
        logic [15:0] r;
        r = s ^ salt;
        return (r == 16'h0) ? 16'hACE1 : r;
    endfunction

    function automatic int model(input int n, input logic [15:0] s);
        logic [15:0] x, y, t;
        longint hits;
        if (n == 0) return 0;
        x = mkseed(s, 16'h0000);
        y = mkseed(s, 16'h5A5A);
        t = mkseed(s, 16'hC3C3);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            x = step16(x); y = step16(y); t = step16(t);
            if ((longint'(t) << 16) <= longint'(x) * longint'(y)) hits++; // R4
        end
        return int'((hits << 16) / n); // R5
    endfunction

    // monitor: pops the scoreboard on every done pulse
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected done", 1, 0);
            end else begin
                automatic int e = exp_q.pop_front();
                automatic string tg = tag_q.pop_front();
                check(int'(result) == e, tg, int'(result), e);
                check(!busy, "R6 busy low at done", int'(busy), 0);
                last_exp = e;
                served++;
            end
        end
    end

    task automatic launch(input int n, input logic [15:0] s, input string tg);
        @(negedge clk);
        n_samples = 20'(n);
        seed      = s;
        start     = 1'b1;
        exp_q.push_back(model(n, s));
        tag_q.push_back(tg);
        issued++;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (served < issued) @(negedge clk);
    endtask

    task automatic run(input int n, input logic [15:0] s, input string tg);
        launch(n, s, tg);
        wait_done();
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(!busy, "R1 busy after reset", int'(busy), 0);
        check(!done, "R1 done after reset", int'(done), 0);
        check(result == 0, "R1 result after reset", int'(result), 0);

        // R2 R4: single samples, each result is 0 or 65536
        run(1, 16'h0001, "R4 N=1 seed 0001");
        run(1, 16'h1234, "R4 N=1 seed 1234");
        run(1, 16'hBEEF, "R2 N=1 seed BEEF");
        run(2, 16'hFFFF, "R2 N=2 seed FFFF");

        // R8: zero samples
        @(negedge clk);
        n_samples = '0; seed = 16'h7777; start = 1'b1;
        exp_q.push_back(0); tag_q.push_back("R8 N=0 result"); issued++;
        @(negedge clk);
        start = 1'b0;
        check(done, "R8 done next cycle", int'(done), 1);
        check(!busy, "R8 busy stays low", int'(busy), 0);
        wait_done();

        // R3: seeds that zero a derived generator
        run(7, 16'h0000, "R3 seed 0000");
        run(7, 16'h5A5A, "R3 seed 5A5A");
        run(7, 16'hC3C3, "R3 seed C3C3");

        // R5: several counts
        run(3, 16'h2468, "R5 N=3");
        run(10, 16'h2468, "R5 N=10");
        run(100, 16'h9ABC, "R5 N=100");

        // R6 hold after done
        repeat (3) @(negedge clk);
        check(!done, "R6 done low after pulse", int'(done), 0);
        check(int'(result) == last_exp, "R6 result held", int'(result), last_exp);

        // R7 R9: interfering start and changed inputs while busy
        launch(50, 16'h0F0F, "R9 N=50 with interference");
        check(busy, "R7 busy after start", int'(busy), 1);
        check(result == 0, "R6 result cleared at start", int'(result), 0);
        @(negedge clk);
        n_samples = 20'd5; seed = 16'h1111; start = 1'b1;
        @(negedge clk);
        start = 1'b0; n_samples = 20'd7; seed = 16'h2222;
        check(busy, "R7 still busy after ignored start", int'(busy), 1);
        wait_done();

        // convergence toward 0.25
        run(4000, 16'hACE1, "R5 N=4000 exact");
        check(last_exp > 12384 && last_exp < 20384 && int'(result) == last_exp,
              "R5 converge near 16384", int'(result), 16384);

        finish_run();
    end
endmodule